// File: doc/BRIEF.md
# Serial Flash Read Fetch Sequencer

This block turns a single word-fetch request into one complete read transaction on a serial NOR flash device and returns the 32-bit result. A host asserts `req` with an address while the engine is idle. The engine then selects one of several flash devices, waits a programmable setup time, and sends an opcode, the address and an optional run of mode clocks. It then reads four data bytes and releases the device after a programmable hold time. The word is presented on `rspData` together with a one-cycle `rspValid` pulse.

The opcode, address and data phases each have their own lane width: one line, two lines or four lines. The serial clock idles low, and its high and low times are counted in system clocks. Outputs change on the falling serial-clock edge and input is captured on the rising edge. A continuous-read option omits the opcode so that a flash already in that state can be read with the address alone. All configuration inputs are treated as static while a transaction is in progress.

Top module: `qfs_fetch_engine`

## Requirements
- R1: After reset `busy`, `rspValid`, `sck` and `ioOe` are all low, and every chip-select output sits at its inactive level.
- R2: A request is taken only in a cycle where `busy` is low. `busy` rises on the next cycle and stays high up to and including the `rspValid` cycle. A `req` seen while `busy` is high is dropped: it starts no second transaction and changes nothing in the current one.
- R3: Unless the opcode is skipped, the transaction opens with `cfgOpcode` sent MSB first in 8, 4 or 2 serial clocks. Lane code 0 means single: the bit goes on `ioOut[0]` with `ioOe`=0001. Code 1 means dual: `ioOut[1:0]` with `ioOe`=0011, higher bit on lane 1. Codes 2 and 3 mean quad: `ioOut[3:0]` with `ioOe`=1111.
- R4: The address phase sends `reqAddr[23:0]`, or all 32 bits when `cfgAddr4B` is set, MSB first. At single, dual and quad width this takes 24/12/6 or 32/16/8 serial clocks.
- R5: The opcode, address and data phases each follow their own lane-code input (`cfgCmdLanes`, `cfgAddrLanes`, `cfgDataLanes`). The total number of serial clocks is the sum of the phase clock counts.
- R6: `cfgModeClks` serial clocks (0 to 15) follow the address. During each of them `ioOut` equals `cfgModeNibble` and `ioOe` is 1111. A count of 0 removes the phase.
- R7: With `cfgSkipCmd` set, no opcode clocks are produced and the first serial clock already carries address bits.
- R8: During the data phase `ioOe` is 0000. The engine samples on each rising `sck` edge: `ioIn[1]` for single, `ioIn[1:0]` for dual, `ioIn[3:0]` for quad. It collects 32 bits MSB first and returns them with the first received byte in `rspData[7:0]` and the fourth in `rspData[31:24]`.
- R9: Each `sck` high time lasts `cfgSckHigh` system clocks and each low time `cfgSckLow`, with 0 treated as 1. `sck` is low outside a transaction. `ioOut` and `ioOe` never change while `sck` is high or in the cycle it rises.
- R10: Only output `csOut[cfgCsSel]` is ever asserted. The asserted level is high when `cfgCsActiveHigh` is 1 and low otherwise.
- R11: The first rising `sck` edge follows chip-select assertion by `cfgCsSetup`+1+low-time system clocks. Chip select stays asserted for `cfgCsHold`+1 system clocks after the last falling `sck` edge and is released in the `rspValid` cycle.
- R12: `rspValid` is a single-cycle pulse, one per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Fetch request, taken when busy is low |
| reqAddr | input | 32 | Fetch byte address |
| busy | output | 1 | Transaction in progress |
| rspValid | output | 1 | One-cycle pulse marking rspData valid |
| rspData | output | 32 | Fetched word, little-endian byte order |
| cfgOpcode | input | 8 | Read opcode |
| cfgCmdLanes | input | 2 | Opcode lane code (0 single, 1 dual, 2/3 quad) |
| cfgAddrLanes | input | 2 | Address lane code |
| cfgDataLanes | input | 2 | Data lane code |
| cfgAddr4B | input | 1 | Send 32 address bits instead of 24 |
| cfgSkipCmd | input | 1 | Omit the opcode phase |
| cfgModeClks | input | 4 | Mode clock count |
| cfgModeNibble | input | 4 | Pattern driven during mode clocks |
| cfgSckHigh | input | 4 | Serial clock high time in system clocks |
| cfgSckLow | input | 4 | Serial clock low time in system clocks |
| cfgCsSetup | input | 4 | Extra cycles between select and first clock |
| cfgCsHold | input | 4 | Extra cycles between last clock and release |
| cfgCsActiveHigh | input | 1 | Chip-select asserted level |
| cfgCsSel | input | 2 | Index of the chip-select output to use |
| sck | output | 1 | Serial clock |
| csOut | output | 4 | Chip-select outputs |
| ioOut | output | 4 | Serial data lines, output value |
| ioOe | output | 4 | Serial data lines, output enable per lane |
| ioIn | input | 4 | Serial data lines, input value |

## Verification
The hardest conditions to reach are the phase boundaries where the lane width changes mid-transaction. The shift register must be reloaded on exactly the falling edge that closes the opcode phase, and the first data bit must be sampled right after a mode or address clock. The bench reaches them with a behavioural flash model that counts rising `sck` edges. The model decides from that count which phase each edge belongs to, captures the lines at that width, and presents read data as a pure function of the edge count and the requested address. A mis-timed reload, a shift by the wrong amount or a sample taken one edge early therefore shows up as a wrong opcode, address or word. A second request is also injected mid-transaction to show that it is dropped.

// File: rtl/qfs_pkg.sv
package qfs_pkg;
  localparam int WORD_W       = 32;
  localparam int OPCODE_W     = 8;
  localparam int ADDR_SHORT_W = 24;
  localparam int IO_W         = 4;
  localparam int BYTE_W       = 8;

  typedef enum logic [1:0] {
    LANE_SINGLE = 2'd0,
    LANE_DUAL   = 2'd1,
    LANE_QUAD   = 2'd2
  } qfsLane_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_CMD, ST_ADDR, ST_MODE, ST_DATA, ST_HOLD, ST_DONE
  } qfsState_e;

  // strobes from sequencing control to the shift datapath
  typedef struct packed {
    logic     captureReq;
    logic     loadAddr;
    logic     shiftTx;
    logic     sampleRx;
    logic     driveTx;
    logic     driveMode;
    qfsLane_e lanes;
  } qfsStrobe_t;

  // codes 2 and 3 both select four lanes
  function automatic qfsLane_e normLane(input logic [1:0] code);
    return code[1] ? LANE_QUAD : qfsLane_e'(code);
  endfunction
endpackage

// File: rtl/qfs_ctrl.sv
module qfs_ctrl
  import qfs_pkg::*;
#(
  parameter int TIME_W = 4,
  parameter int CLK_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic [1:0]        cfgCmdLanes,
  input  logic [1:0]        cfgAddrLanes,
  input  logic [1:0]        cfgDataLanes,
  input  logic              cfgAddr4B,
  input  logic              cfgSkipCmd,
  input  logic [TIME_W-1:0] cfgModeClks,
  input  logic [TIME_W-1:0] cfgSckHigh,
  input  logic [TIME_W-1:0] cfgSckLow,
  input  logic [TIME_W-1:0] cfgCsSetup,
  input  logic [TIME_W-1:0] cfgCsHold,
  output qfsStrobe_t        strobe,
  output logic              busy,
  output logic              rspValid,
  output logic              sck,
  output logic              csActive
);
  qfsState_e         state;
  logic [TIME_W-1:0] timeCnt;
  logic [CLK_W-1:0]  clkLeft;
  logic              sckReg;

  logic              activePh, atZero, riseNow, fallNow, lastClk;
  qfsState_e         firstPh, afterPh, nextPh;
  logic [CLK_W-1:0]  cmdClks, addrClks, modeClks, dataClks, nextClks;
  logic [TIME_W-1:0] highLoad, lowLoad;

  // a zero time count behaves as one system clock
  assign highLoad = (cfgSckHigh == '0) ? '0 : cfgSckHigh - 1'b1;
  assign lowLoad  = (cfgSckLow  == '0) ? '0 : cfgSckLow  - 1'b1;

  assign cmdClks  = CLK_W'(OPCODE_W >> int'(normLane(cfgCmdLanes)));
  assign addrClks = CLK_W'((cfgAddr4B ? WORD_W : ADDR_SHORT_W) >> int'(normLane(cfgAddrLanes)));
  assign modeClks = CLK_W'(cfgModeClks);
  assign dataClks = CLK_W'(WORD_W >> int'(normLane(cfgDataLanes)));

  assign activePh = (state == ST_CMD) || (state == ST_ADDR) ||
                    (state == ST_MODE) || (state == ST_DATA);
  assign atZero   = (timeCnt == '0);
  assign riseNow  = activePh && !sckReg && atZero;
  assign fallNow  = activePh && sckReg && atZero;
  assign lastClk  = (clkLeft == CLK_W'(1));

  assign firstPh = cfgSkipCmd ? ST_ADDR : ST_CMD;

  always_comb begin
    case (state)
      ST_CMD:  afterPh = ST_ADDR;
      ST_ADDR: afterPh = (cfgModeClks != '0) ? ST_MODE : ST_DATA;
      ST_MODE: afterPh = ST_DATA;
      default: afterPh = ST_HOLD;
    endcase
    nextPh = (state == ST_SETUP) ? firstPh : afterPh;
    case (nextPh)
      ST_CMD:  nextClks = cmdClks;
      ST_ADDR: nextClks = addrClks;
      ST_MODE: nextClks = modeClks;
      ST_DATA: nextClks = dataClks;
      default: nextClks = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      timeCnt <= '0;
      clkLeft <= '0;
      sckReg  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req) begin
            state   <= ST_SETUP;
            timeCnt <= cfgCsSetup;
          end
        end
        ST_SETUP: begin
          if (atZero) begin
            state   <= nextPh;
            clkLeft <= nextClks;
            timeCnt <= lowLoad;
          end else begin
            timeCnt <= timeCnt - 1'b1;
          end
        end
        ST_CMD, ST_ADDR, ST_MODE, ST_DATA: begin
          if (!atZero) begin
            timeCnt <= timeCnt - 1'b1;
          end else if (!sckReg) begin
            sckReg  <= 1'b1;
            timeCnt <= highLoad;
          end else begin
            sckReg <= 1'b0;
            if (lastClk) begin
              state <= nextPh;
              if (nextPh == ST_HOLD) begin
                timeCnt <= cfgCsHold;
              end else begin
                clkLeft <= nextClks;
                timeCnt <= lowLoad;
              end
            end else begin
              clkLeft <= clkLeft - 1'b1;
              timeCnt <= lowLoad;
            end
          end
        end
        ST_HOLD: begin
          if (atZero) state <= ST_DONE;
          else        timeCnt <= timeCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.captureReq = (state == ST_IDLE) && req;
    strobe.loadAddr   = ((state == ST_SETUP) && atZero && cfgSkipCmd) ||
                        ((state == ST_CMD) && fallNow && lastClk);
    strobe.shiftTx    = fallNow && !lastClk;
    strobe.sampleRx   = riseNow && (state == ST_DATA);
    strobe.driveTx    = (state == ST_CMD) || (state == ST_ADDR);
    strobe.driveMode  = (state == ST_MODE);
    case (state)
      ST_CMD:  strobe.lanes = normLane(cfgCmdLanes);
      ST_ADDR: strobe.lanes = normLane(cfgAddrLanes);
      ST_DATA: strobe.lanes = normLane(cfgDataLanes);
      default: strobe.lanes = LANE_SINGLE;
    endcase
  end

  assign busy     = (state != ST_IDLE);
  assign rspValid = (state == ST_DONE);
  assign csActive = (state != ST_IDLE) && (state != ST_DONE);
  assign sck      = sckReg;
endmodule

// File: rtl/qfs_datapath.sv
module qfs_datapath
  import qfs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  qfsStrobe_t        strobe,
  input  logic [OPCODE_W-1:0] cfgOpcode,
  input  logic              cfgAddr4B,
  input  logic [IO_W-1:0]   cfgModeNibble,
  input  logic [WORD_W-1:0] reqAddr,
  input  logic [IO_W-1:0]   ioIn,
  output logic [IO_W-1:0]   ioOut,
  output logic [IO_W-1:0]   ioOe,
  output logic [WORD_W-1:0] rspData
);
  localparam int PAD_W     = WORD_W - ADDR_SHORT_W;
  localparam int OP_PAD_W  = WORD_W - OPCODE_W;
  localparam int BYTES     = WORD_W / BYTE_W;

  logic [WORD_W-1:0] addrHold;
  logic [WORD_W-1:0] txShift;
  logic [WORD_W-1:0] rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHold <= '0;
      txShift  <= '0;
      rxShift  <= '0;
    end else begin
      if (strobe.captureReq) begin
        addrHold <= reqAddr;
        txShift  <= {cfgOpcode, {OP_PAD_W{1'b0}}};
        rxShift  <= '0;
      end else if (strobe.loadAddr) begin
        txShift <= cfgAddr4B ? addrHold : {addrHold[ADDR_SHORT_W-1:0], {PAD_W{1'b0}}};
      end else if (strobe.shiftTx) begin
        case (strobe.lanes)
          LANE_DUAL: txShift <= {txShift[WORD_W-3:0], 2'b00};
          LANE_QUAD: txShift <= {txShift[WORD_W-5:0], 4'b0000};
          default:   txShift <= {txShift[WORD_W-2:0], 1'b0};
        endcase
      end
      if (strobe.sampleRx) begin
        case (strobe.lanes)
          LANE_DUAL: rxShift <= {rxShift[WORD_W-3:0], ioIn[1:0]};
          LANE_QUAD: rxShift <= {rxShift[WORD_W-5:0], ioIn};
          default:   rxShift <= {rxShift[WORD_W-2:0], ioIn[1]};
        endcase
      end
    end
  end

  always_comb begin
    ioOut = '0;
    ioOe  = '0;
    if (strobe.driveMode) begin
      ioOut = cfgModeNibble;
      ioOe  = '1;
    end else if (strobe.driveTx) begin
      case (strobe.lanes)
        LANE_DUAL: begin ioOut = {2'b00, txShift[WORD_W-1 -: 2]}; ioOe = 4'b0011; end
        LANE_QUAD: begin ioOut = txShift[WORD_W-1 -: 4];          ioOe = 4'b1111; end
        default:   begin ioOut = {3'b000, txShift[WORD_W-1]};     ioOe = 4'b0001; end
      endcase
    end
  end

  // first byte received lands in the least significant byte
  for (genvar b = 0; b < BYTES; b++) begin : g_swap
    assign rspData[b*BYTE_W +: BYTE_W] = rxShift[WORD_W-(b+1)*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/qfs_fetch_engine.sv
module qfs_fetch_engine
  import qfs_pkg::*;
#(
  parameter int CS_COUNT = 4,
  parameter int TIME_W   = 4,
  localparam int CS_SEL_W = (CS_COUNT > 1) ? $clog2(CS_COUNT) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                req,
  input  logic [31:0]         reqAddr,
  output logic                busy,
  output logic                rspValid,
  output logic [31:0]         rspData,
  input  logic [7:0]          cfgOpcode,
  input  logic [1:0]          cfgCmdLanes,
  input  logic [1:0]          cfgAddrLanes,
  input  logic [1:0]          cfgDataLanes,
  input  logic                cfgAddr4B,
  input  logic                cfgSkipCmd,
  input  logic [TIME_W-1:0]   cfgModeClks,
  input  logic [3:0]          cfgModeNibble,
  input  logic [TIME_W-1:0]   cfgSckHigh,
  input  logic [TIME_W-1:0]   cfgSckLow,
  input  logic [TIME_W-1:0]   cfgCsSetup,
  input  logic [TIME_W-1:0]   cfgCsHold,
  input  logic                cfgCsActiveHigh,
  input  logic [CS_SEL_W-1:0] cfgCsSel,
  output logic                sck,
  output logic [CS_COUNT-1:0] csOut,
  output logic [3:0]          ioOut,
  output logic [3:0]          ioOe,
  input  logic [3:0]          ioIn
);
  qfsStrobe_t strobe;
  logic       csActive;

  qfs_ctrl #(.TIME_W(TIME_W), .CLK_W(6)) u_ctrl (
    .clk(clk), .rstN(rstN), .req(req),
    .cfgCmdLanes(cfgCmdLanes), .cfgAddrLanes(cfgAddrLanes), .cfgDataLanes(cfgDataLanes),
    .cfgAddr4B(cfgAddr4B), .cfgSkipCmd(cfgSkipCmd), .cfgModeClks(cfgModeClks),
    .cfgSckHigh(cfgSckHigh), .cfgSckLow(cfgSckLow),
    .cfgCsSetup(cfgCsSetup), .cfgCsHold(cfgCsHold),
    .strobe(strobe), .busy(busy), .rspValid(rspValid), .sck(sck), .csActive(csActive)
  );

  qfs_datapath u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgOpcode(cfgOpcode), .cfgAddr4B(cfgAddr4B), .cfgModeNibble(cfgModeNibble),
    .reqAddr(reqAddr), .ioIn(ioIn), .ioOut(ioOut), .ioOe(ioOe), .rspData(rspData)
  );

  for (genvar i = 0; i < CS_COUNT; i++) begin : g_cs
    assign csOut[i] = (csActive && (cfgCsSel == CS_SEL_W'(i))) ? cfgCsActiveHigh : !cfgCsActiveHigh;
  end
endmodule

// File: rtl/qfs_fetch_checker.sv
module qfs_fetch_checker #(
  parameter int CS_COUNT = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                req,
  input logic                busy,
  input logic                rspValid,
  input logic                sck,
  input logic [3:0]          ioOut,
  input logic [3:0]          ioOe,
  input logic [CS_COUNT-1:0] csOut,
  input logic                cfgCsActiveHigh
);
  logic [CS_COUNT-1:0] csAsserted;
  assign csAsserted = cfgCsActiveHigh ? csOut : ~csOut;

  assert_accept_sets_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (req && !busy) |=> busy);
  assert_busy_until_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !rspValid) |=> busy);
  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && !busy));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sck && ioOe == 4'b0000 && csAsserted == '0));
  assert_cs_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(csAsserted));
  assert_sck_in_frame_R11: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> ($countones(csAsserted) == 1));
  assert_release_at_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (csAsserted == '0));
  assert_out_steady_R9: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> ($stable(ioOut) && $stable(ioOe)));
endmodule

bind qfs_fetch_engine qfs_fetch_checker #(.CS_COUNT(CS_COUNT)) u_qfsChk (
  .clk(clk), .rstN(rstN), .req(req), .busy(busy), .rspValid(rspValid),
  .sck(sck), .ioOut(ioOut), .ioOe(ioOe), .csOut(csOut), .cfgCsActiveHigh(cfgCsActiveHigh)
);

// File: tb/qfs_fetch_engine_bench.sv
module qfs_fetch_engine_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, req, busy, rspValid, sck;
  logic [31:0] reqAddr, rspData;
  logic [7:0]  cfgOpcode;
  logic [1:0]  cfgCmdLanes, cfgAddrLanes, cfgDataLanes, cfgCsSel;
  logic        cfgAddr4B, cfgSkipCmd, cfgCsActiveHigh;
  logic [3:0]  cfgModeClks, cfgModeNibble, cfgSckHigh, cfgSckLow, cfgCsSetup, cfgCsHold;
  logic [3:0]  csOut, ioOut, ioOe, ioIn;

  qfs_fetch_engine u_qfs_fetch_engine (
    .clk(clk), .rstN(rstN), .req(req), .reqAddr(reqAddr), .busy(busy),
    .rspValid(rspValid), .rspData(rspData), .cfgOpcode(cfgOpcode),
    .cfgCmdLanes(cfgCmdLanes), .cfgAddrLanes(cfgAddrLanes), .cfgDataLanes(cfgDataLanes),
    .cfgAddr4B(cfgAddr4B), .cfgSkipCmd(cfgSkipCmd), .cfgModeClks(cfgModeClks),
    .cfgModeNibble(cfgModeNibble), .cfgSckHigh(cfgSckHigh), .cfgSckLow(cfgSckLow),
    .cfgCsSetup(cfgCsSetup), .cfgCsHold(cfgCsHold), .cfgCsActiveHigh(cfgCsActiveHigh),
    .cfgCsSel(cfgCsSel), .sck(sck), .csOut(csOut), .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn)
  );

  int vecs = 0;
  int bad  = 0;

  // flash model state, cleared by each scenario
  int          riseCnt, cmdN, addrN, modeN, preN, dataN, dataL;
  int          csLead, curHigh, curLow, highLen, lowLen, tailLen;
  int          oeBad, modeBad, otherCsBad, rspCnt;
  logic [31:0] cmdCap, addrCap, expStream;
  logic        prevSck, prevAct;

  function automatic int lc(input logic [1:0] c);
    return (c == 2'd0) ? 1 : ((c == 2'd1) ? 2 : 4);
  endfunction

  function automatic logic [7:0] flashByte(input logic [31:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // read data presented as a function of the rising-edge count
  always_comb begin
    ioIn = 4'h0;
    if (riseCnt >= preN && riseCnt < preN + dataN) begin
      if (dataL == 1) begin
        ioIn[1] = expStream[31 - (riseCnt - preN)];
        ioIn[0] = ~ioIn[1];
      end else if (dataL == 2) begin
        ioIn[1:0] = 2'(expStream >> (32 - 2 * (riseCnt - preN + 1)));
      end else begin
        ioIn = 4'(expStream >> (32 - 4 * (riseCnt - preN + 1)));
      end
    end
  end

  always @(negedge clk) begin
    logic sAct;
    int   L;
    sAct = cfgCsActiveHigh ? csOut[cfgCsSel] : !csOut[cfgCsSel];
    for (int i = 0; i < 4; i++)
      if (i != int'(cfgCsSel) && csOut[i] !== !cfgCsActiveHigh) otherCsBad++;
    if (sAct) begin
      if (sck && !prevSck) begin
        if (riseCnt < cmdN) begin
          L = lc(cfgCmdLanes);
          cmdCap = (cmdCap << L) | 32'(ioOut & 4'((1 << L) - 1));
          if (ioOe !== 4'((1 << L) - 1)) oeBad++;
        end else if (riseCnt < cmdN + addrN) begin
          L = lc(cfgAddrLanes);
          addrCap = (addrCap << L) | 32'(ioOut & 4'((1 << L) - 1));
          if (ioOe !== 4'((1 << L) - 1)) oeBad++;
        end else if (riseCnt < preN) begin
          if (ioOut !== cfgModeNibble || ioOe !== 4'hF) modeBad++;
        end else begin
          if (ioOe !== 4'h0) oeBad++;
        end
        if (riseCnt == 1) lowLen = curLow;
        curHigh = 1;
        riseCnt++;
      end else if (!sck && prevSck) begin
        if (riseCnt == 1) highLen = curHigh;
        curLow = 1;
      end else if (sck) begin
        curHigh++;
      end else if (riseCnt == 0) begin
        csLead++;
      end else begin
        curLow++;
      end
    end
    if (!sAct && prevAct) tailLen = curLow;
    if (rspValid) rspCnt++;
    prevSck = sck;
    prevAct = sAct;
  end

  task automatic clearModel(input logic [31:0] addr);
    logic [31:0] a;
    a = cfgAddr4B ? addr : {8'h00, addr[23:0]};
    riseCnt = 0; csLead = 0; curHigh = 0; curLow = 0; highLen = 0; lowLen = 0; tailLen = 0;
    oeBad = 0; modeBad = 0; otherCsBad = 0; rspCnt = 0; cmdCap = 0; addrCap = 0;
    cmdN  = cfgSkipCmd ? 0 : 8 / lc(cfgCmdLanes);
    addrN = (cfgAddr4B ? 32 : 24) / lc(cfgAddrLanes);
    modeN = int'(cfgModeClks);
    preN  = cmdN + addrN + modeN;
    dataL = lc(cfgDataLanes);
    dataN = 32 / dataL;
    expStream = {flashByte(a), flashByte(a + 1), flashByte(a + 2), flashByte(a + 3)};
  endtask

  // one full read, optionally with a second request injected while busy
  task automatic doFetch(input string tag, input logic [31:0] addr, input bit intrude);
    logic [31:0] a, got;
    logic        busyAtPulse;
    int          hiEff, loEff;
    a = cfgAddr4B ? addr : {8'h00, addr[23:0]};
    hiEff = (cfgSckHigh == 0) ? 1 : int'(cfgSckHigh);
    loEff = (cfgSckLow == 0) ? 1 : int'(cfgSckLow);
    @(posedge clk); #1;
    clearModel(addr);
    while (busy) begin @(posedge clk); #1; end
    req = 1'b1; reqAddr = addr;
    @(posedge clk); #1;
    req = 1'b0; reqAddr = 32'hDEAD_BEEF;
    if (intrude) begin
      repeat (6) @(posedge clk);
      #1 req = 1'b1; reqAddr = 32'h0055_AA00;
      @(posedge clk); #1 req = 1'b0;
    end
    @(negedge clk);
    while (!rspValid) @(negedge clk);
    got = rspData; busyAtPulse = busy;
    repeat (3) @(posedge clk);
    #1;
    if (!cfgSkipCmd) chk({tag, " R3 opcode"}, 64'(cmdCap), 64'(cfgOpcode));
    else             chk({tag, " R7 no opcode bits"}, 64'(cmdCap), 64'd0);
    chk({tag, " R4 address"}, 64'(addrCap), 64'(a));
    chk({tag, " R5 total serial clocks"}, 64'(riseCnt), 64'(preN + dataN));
    chk({tag, " R8 word little-endian"}, 64'(got),
        64'({flashByte(a + 3), flashByte(a + 2), flashByte(a + 1), flashByte(a)}));
    chk({tag, " R8 R3 output enables"}, 64'(oeBad), 64'd0);
    chk({tag, " R6 mode pattern"}, 64'(modeBad), 64'd0);
    chk({tag, " R9 high time"}, 64'(highLen), 64'(hiEff));
    chk({tag, " R9 low time"}, 64'(lowLen), 64'(loEff));
    chk({tag, " R11 select lead"}, 64'(csLead), 64'(int'(cfgCsSetup) + 1 + loEff));
    chk({tag, " R11 select tail"}, 64'(tailLen), 64'(int'(cfgCsHold) + 1));
    chk({tag, " R10 other selects idle"}, 64'(otherCsBad), 64'd0);
    chk({tag, " R2 busy at pulse"}, 64'(busyAtPulse), 64'd1);
    if (intrude) begin
      repeat (40) @(posedge clk);
      #1;
      chk({tag, " R12 R2 one response only"}, 64'(rspCnt), 64'd1);
      chk({tag, " R2 idle after drop"}, 64'(busy), 64'd0);
    end
  endtask

  task automatic setCfg(input logic [7:0] op, input logic [1:0] cl, input logic [1:0] al,
                        input logic [1:0] dl, input logic a4, input logic skip,
                        input logic [3:0] mc, input logic [3:0] mn, input logic [3:0] hi,
                        input logic [3:0] lo, input logic [3:0] su, input logic [3:0] ho,
                        input logic pol, input logic [1:0] sel);
    cfgOpcode = op; cfgCmdLanes = cl; cfgAddrLanes = al; cfgDataLanes = dl;
    cfgAddr4B = a4; cfgSkipCmd = skip; cfgModeClks = mc; cfgModeNibble = mn;
    cfgSckHigh = hi; cfgSckLow = lo; cfgCsSetup = su; cfgCsHold = ho;
    cfgCsActiveHigh = pol; cfgCsSel = sel;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 rspValid", 64'(rspValid), 64'd0);
    chk("R1 sck", 64'(sck), 64'd0);
    chk("R1 ioOe", 64'(ioOe), 64'd0);
    chk("R1 selects inactive", 64'(csOut), 64'hF);
  endtask

  task automatic testSingle();
    setCfg(8'h03, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0, 4'h0, 4'd2, 4'd2, 4'd1, 4'd1, 1'b0, 2'd0);
    doFetch("single", 32'hFF12_3456, 1'b0);
  endtask

  task automatic testQuadFast();
    setCfg(8'hEB, 2'd2, 2'd2, 2'd2, 1'b1, 1'b0, 4'd2, 4'hA, 4'd1, 4'd1, 4'd0, 4'd0, 1'b1, 2'd2);
    doFetch("quad4B", 32'h89AB_CDEF, 1'b0);
  endtask

  task automatic testMixed();
    setCfg(8'h6B, 2'd0, 2'd2, 2'd1, 1'b0, 1'b0, 4'd4, 4'h5, 4'd3, 4'd5, 4'd0, 4'd3, 1'b0, 2'd1);
    doFetch("mixed", 32'h0001_02FD, 1'b0);
  endtask

  task automatic testSkipCmd();
    setCfg(8'hBB, 2'd0, 2'd1, 2'd3, 1'b0, 1'b1, 4'd0, 4'h0, 4'd0, 4'd0, 4'd2, 4'd0, 1'b0, 2'd3);
    doFetch("skipcmd", 32'h00C0_FFEE, 1'b0);
  endtask

  task automatic testSlowClock();
    setCfg(8'h0B, 2'd1, 2'd0, 2'd0, 1'b1, 1'b0, 4'd15, 4'h3, 4'd15, 4'd15, 4'd15, 4'd15, 1'b1, 2'd0);
    doFetch("slow", 32'h1357_9BDF, 1'b0);
  endtask

  task automatic testDropWhileBusy();
    setCfg(8'h3B, 2'd0, 2'd1, 2'd1, 1'b0, 1'b0, 4'd1, 4'hC, 4'd2, 4'd1, 4'd0, 4'd2, 1'b0, 2'd0);
    doFetch("dropbusy", 32'h0024_6800, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    prevSck = 1'b0; prevAct = 1'b0;
    req = 1'b0; reqAddr = '0; rstN = 1'b0;
    setCfg(8'h03, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 4'd0, 4'h0, 4'd1, 4'd1, 4'd0, 4'd0, 1'b0, 2'd0);
    clearModel(32'h0);
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testSingle();
    testQuadFast();
    testMixed();
    testSkipCmd();
    testSlowClock();
    testDropWhileBusy();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule